// File: doc/BRIEF.md
# Masked-Configuration GPIO Bank

This block is a single bank of general-purpose I/O lines, reached over a simple word-addressed register bus with a one-cycle write strobe and a combinational read port. Every line owns a configuration word: a peripheral function selector, a direction bit, pad controls (pull-up, pull-down, input filter, slow filter, open-drain, Schmitt control) and an interrupt event selector. All lines share one configuration address. A line-select register decides which lines a configuration write updates and which line a configuration read shows. The pad control bits are exported as per-line vectors, so the pad ring and the pin multiplexer can use them directly.

Output levels are changed through separate set and clear registers, so software never needs a read-modify-write. An output-data register reads back the levels now being driven. Input pins pass through a two-flop synchronizer. Software can read the synchronized levels. A per-line detector watches those levels for the event chosen in that line's configuration. Detected events collect in a status register that clears when it is read. Interrupt enable and disable registers build a read-only interrupt mask. One interrupt output is high while any pending event is also enabled.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, all exported outputs are 0 and `irq` is low.
- R2: A write to offset 0x04 updates only the lines whose bit is 1 in the line-select register (offset 0x00). Within the word, bits [2:0] hold the function, bit 8 the direction (1 = output), bit 9 the pull-up, bit 10 the pull-down, bit 12 the filter enable, bit 13 the slow filter, bit 14 open-drain, bit 15 Schmitt control and bits [26:24] the event selector. All other bits read back as 0.
- R3: A read of offset 0x04 returns the configuration of the lowest-numbered line that is selected. With no line selected, it returns 0.
- R4: A 1 written to offset 0x10 drives that line high. A 1 written to offset 0x14 drives it low. Bits written as 0 leave their lines unchanged. Offset 0x18 reads the driven levels, which also appear on `out_val`.
- R5: Each line's function appears on `func_sel[3*i+2:3*i]`. The direction appears on `out_en`, and each pad control bit appears on its own output vector.
- R6: Writing 1s to offset 0x20 sets interrupt mask bits, and writing 1s to offset 0x24 clears them. Offset 0x28 reads the mask, and a write to offset 0x28 has no effect.
- R7: Offset 0x08 returns the pin levels as they were two clock edges earlier.
- R8: The event selector codes are 0 = falling edge, 1 = rising edge, 2 = both edges, 3 = low level and 4 = high level. Edges are judged on the synchronized level, and a detected event becomes pending one edge after the synchronized level shows it.
- R9: A read of offset 0x2C returns the pending events and clears them. An event that arrives in the same cycle as the read stays pending, so a persisting level event is reported again by the next read.
- R10: `irq` is high exactly when some pending bit is also set in the interrupt mask.
- R11: Reads of offset 0x0C, of the write-only offsets and of unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| pins_in | input | 32 | Asynchronous pin levels |
| out_val | output | 32 | Driven output levels |
| out_en | output | 32 | Per-line output enable (direction) |
| func_sel | output | 96 | Three-bit function selector per line |
| pull_up | output | 32 | Pull-up enables |
| pull_dn | output | 32 | Pull-down enables |
| filt_en | output | 32 | Input filter enables |
| filt_slow | output | 32 | Slow filter enables |
| open_drain | output | 32 | Open-drain enables |
| schmitt | output | 32 | Schmitt control bits |
| irq | output | 1 | Combined bank interrupt |

## Verification
Random configuration writes under random line-select values, some with no line selected and some with many, test two things: whether unselected lines keep their words, and whether the read returns the lowest selected line rather than any other. Random set and clear patterns, and random enable and disable patterns, show whether 0 bits really are ignored. A directed sequence gives five lines the five event codes and drives all of them through the same rising and falling pin steps. This shows whether each detector tells edge from level and rising from falling. Repeated status reads show whether an edge is cleared while a level persists. Toggling the mask while an event is pending checks the interrupt gating.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int CFG_W = 32;

    localparam logic [5:0] OFF_SEL  = 6'h00;
    localparam logic [5:0] OFF_CFG  = 6'h04;
    localparam logic [5:0] OFF_PIN  = 6'h08;
    localparam logic [5:0] OFF_LOCK = 6'h0C;
    localparam logic [5:0] OFF_SET  = 6'h10;
    localparam logic [5:0] OFF_CLR  = 6'h14;
    localparam logic [5:0] OFF_OUT  = 6'h18;
    localparam logic [5:0] OFF_IEN  = 6'h20;
    localparam logic [5:0] OFF_IDIS = 6'h24;
    localparam logic [5:0] OFF_IMSK = 6'h28;
    localparam logic [5:0] OFF_IST  = 6'h2C;

    localparam logic [2:0] EV_FALL = 3'd0;
    localparam logic [2:0] EV_RISE = 3'd1;
    localparam logic [2:0] EV_BOTH = 3'd2;
    localparam logic [2:0] EV_LOW  = 3'd3;
    localparam logic [2:0] EV_HIGH = 3'd4;

    typedef struct packed {
        logic [2:0] evsel;
        logic       schm;
        logic       odrain;
        logic       slowf;
        logic       filt;
        logic       pdn;
        logic       pup;
        logic       dir;
        logic [2:0] func;
    } line_cfg_t;

    function automatic line_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        line_cfg_t c;
        c.func   = w[2:0];
        c.dir    = w[8];
        c.pup    = w[9];
        c.pdn    = w[10];
        c.filt   = w[12];
        c.slowf  = w[13];
        c.odrain = w[14];
        c.schm   = w[15];
        c.evsel  = w[26:24];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input line_cfg_t c);
        logic [CFG_W-1:0] w;
        w        = '0;
        w[2:0]   = c.func;
        w[8]     = c.dir;
        w[9]     = c.pup;
        w[10]    = c.pdn;
        w[12]    = c.filt;
        w[13]    = c.slowf;
        w[14]    = c.odrain;
        w[15]    = c.schm;
        w[26:24] = c.evsel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> sync_out == $past(async_in, 2)); // R7
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [3*W-1:0] evsel,
    output logic [W-1:0]   hit
);
    logic [W-1:0] prev_d, prev_q;

    assign prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [2:0] sel;
        logic       rise, fall;
        assign sel  = evsel[3*i +: 3];
        assign rise = lvl[i] & ~prev_q[i];
        assign fall = ~lvl[i] & prev_q[i];
        always_comb begin
            case (sel)
                EV_FALL: hit[i] = fall;
                EV_RISE: hit[i] = rise;
                EV_BOTH: hit[i] = rise | fall;
                EV_LOW:  hit[i] = ~lvl[i];
                EV_HIGH: hit[i] = lvl[i];
                default: hit[i] = 1'b0;
            endcase
        end
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && (evsel[2:0] <= EV_BOTH)) |-> (lvl[0] != prev_q[0])); // R8
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    input  logic [NLINES-1:0] pins_in,
    output logic [NLINES-1:0] out_val,
    output logic [NLINES-1:0] out_en,
    output logic [3*NLINES-1:0] func_sel,
    output logic [NLINES-1:0] pull_up,
    output logic [NLINES-1:0] pull_dn,
    output logic [NLINES-1:0] filt_en,
    output logic [NLINES-1:0] filt_slow,
    output logic [NLINES-1:0] open_drain,
    output logic [NLINES-1:0] schmitt,
    output logic              irq
);
    typedef struct packed {
        logic [NLINES-1:0]            sel;
        line_cfg_t [NLINES-1:0]       cfg;
        logic [NLINES-1:0]            odat;
        logic [NLINES-1:0]            imsk;
        logic [NLINES-1:0]            pend;
    } bank_t;

    bank_t st_d, st_q;

    logic [NLINES-1:0]   lvl;
    logic [NLINES-1:0]   hit;
    logic [3*NLINES-1:0] evsel;
    logic [CFG_W-1:0]    cfg_rd;
    logic                rd_ist;
    logic [AW-1:0]       a_sel, a_cfg, a_pin, a_set, a_clr, a_out, a_ien, a_idis, a_imsk, a_ist;

    assign a_sel  = AW'(OFF_SEL);
    assign a_cfg  = AW'(OFF_CFG);
    assign a_pin  = AW'(OFF_PIN);
    assign a_set  = AW'(OFF_SET);
    assign a_clr  = AW'(OFF_CLR);
    assign a_out  = AW'(OFF_OUT);
    assign a_ien  = AW'(OFF_IEN);
    assign a_idis = AW'(OFF_IDIS);
    assign a_imsk = AW'(OFF_IMSK);
    assign a_ist  = AW'(OFF_IST);

    gpio_sync2 #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins_in), .sync_out(lvl)
    );

    gpio_evt_det #(.W(NLINES)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .evsel(evsel), .hit(hit)
    );

    // lowest selected line wins the configuration read
    always_comb begin
        cfg_rd = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (st_q.sel[i]) cfg_rd = cfg_pack(st_q.cfg[i]);
        end
    end

    assign rd_ist = rd_en && (addr == a_ist);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == a_sel)       rdata = st_q.sel;
            else if (addr == a_cfg)  rdata = NLINES'(cfg_rd);
            else if (addr == a_pin)  rdata = lvl;
            else if (addr == a_out)  rdata = st_q.odat;
            else if (addr == a_imsk) rdata = st_q.imsk;
            else if (addr == a_ist)  rdata = st_q.pend;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == a_sel) st_d.sel = wdata;
            if (addr == a_cfg) begin
                for (int i = 0; i < NLINES; i++) begin
                    if (st_q.sel[i]) st_d.cfg[i] = cfg_unpack(CFG_W'(wdata));
                end
            end
            if (addr == a_set)  st_d.odat = st_q.odat | wdata;
            if (addr == a_clr)  st_d.odat = st_q.odat & ~wdata;
            if (addr == a_ien)  st_d.imsk = st_q.imsk | wdata;
            if (addr == a_idis) st_d.imsk = st_q.imsk & ~wdata;
        end
        st_d.pend = (rd_ist ? '0 : st_q.pend) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NLINES; i++) begin
            evsel[3*i +: 3]    = st_q.cfg[i].evsel;
            func_sel[3*i +: 3] = st_q.cfg[i].func;
            out_en[i]          = st_q.cfg[i].dir;
            pull_up[i]         = st_q.cfg[i].pup;
            pull_dn[i]         = st_q.cfg[i].pdn;
            filt_en[i]         = st_q.cfg[i].filt;
            filt_slow[i]       = st_q.cfg[i].slowf;
            open_drain[i]      = st_q.cfg[i].odrain;
            schmitt[i]         = st_q.cfg[i].schm;
        end
    end

    assign out_val = st_q.odat;
    assign irq     = |(st_q.pend & st_q.imsk);

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == a_set) |=> ((out_val & $past(wdata)) == $past(wdata))); // R4
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == a_clr) |=> ((out_val & $past(wdata)) == '0)); // R4
    AST_ENABLE_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == a_ien) |=> ((st_q.imsk & $past(wdata)) == $past(wdata))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ist |=> (st_q.pend == $past(hit))); // R9
    AST_EMPTY_SELECT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == a_cfg && st_q.sel == '0) |-> (rdata == '0)); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.imsk == '0) |-> !irq); // R10
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/100ps
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, pins_in = '0;
    logic [31:0] out_val, out_en, pull_up, pull_dn, filt_en, filt_slow, open_drain, schmitt;
    logic [95:0] func_sel;
    logic        irq;

    localparam logic [31:0] CMASK = 32'h0700_F707;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] cfg_m [32];
    logic [31:0] sel_m, odat_m, imsk_m;

    always #2.5 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .out_val(out_val),
        .out_en(out_en), .func_sel(func_sel), .pull_up(pull_up), .pull_dn(pull_dn),
        .filt_en(filt_en), .filt_slow(filt_slow), .open_drain(open_drain),
        .schmitt(schmitt), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) cfg_m[i] = '0;
        sel_m = '0; odat_m = '0; imsk_m = '0;
        idle(1);
    endtask

    function automatic logic [31:0] lowest_cfg(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return cfg_m[i];
        return 32'h0;
    endfunction

    task automatic cfg_write(input logic [31:0] m, input logic [31:0] d);
        wr(6'h00, m);
        wr(6'h04, d);
        sel_m = m;
        for (int i = 0; i < 32; i++) if (m[i]) cfg_m[i] = d & CMASK;
    endtask

    task automatic check_pads(input string tag);
        logic [31:0] e_en, e_pu, e_pd, e_f, e_fs, e_od, e_sc;
        logic [95:0] e_fn;
        for (int i = 0; i < 32; i++) begin
            e_fn[3*i +: 3] = cfg_m[i][2:0];
            e_en[i] = cfg_m[i][8];  e_pu[i] = cfg_m[i][9];  e_pd[i] = cfg_m[i][10];
            e_f[i]  = cfg_m[i][12]; e_fs[i] = cfg_m[i][13]; e_od[i] = cfg_m[i][14];
            e_sc[i] = cfg_m[i][15];
        end
        chk({tag, " out_en"}, out_en, e_en);
        chk({tag, " pull_up"}, pull_up, e_pu);
        chk({tag, " pull_dn"}, pull_dn, e_pd);
        chk({tag, " filt"}, filt_en | (filt_slow << 0) & 32'h0 | filt_en & 32'h0, e_f);
        chk({tag, " filt_slow"}, filt_slow, e_fs);
        chk({tag, " open_drain"}, open_drain, e_od);
        chk({tag, " schmitt"}, schmitt, e_sc);
        chk({tag, " func lo"}, func_sel[31:0], e_fn[31:0]);
        chk({tag, " func mid"}, func_sel[63:32], e_fn[63:32]);
        chk({tag, " func hi"}, func_sel[95:64], e_fn[95:64]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m, d;
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state
        foreach (cfg_m[k]) cfg_m[k] = '0;
        for (int a = 0; a < 64; a += 4) begin
            rd(a[5:0], v);
            chk($sformatf("R1 reset read %h", a), v, 32'h0);
        end
        chk("R1 out_val", out_val, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        check_pads("R1");

        // R2/R3 directed: one line, unselected neighbour untouched
        cfg_write(32'h0000_0004, 32'hFFFF_FFFF);
        rd(6'h04, v); chk("R2 field mask", v, CMASK);
        wr(6'h00, 32'h0000_0008); sel_m = 32'h8;
        rd(6'h04, v); chk("R2 neighbour untouched", v, 32'h0);
        wr(6'h00, 32'h0000_000C);
        rd(6'h04, v); chk("R3 lowest selected", v, CMASK);
        wr(6'h00, 32'h0);
        rd(6'h04, v); chk("R3 empty select", v, 32'h0);
        cfg_write(32'h0, 32'h0000_0101);
        check_pads("R2 empty-select write");

        // R2/R3/R5 random
        for (int it = 0; it < 60; it++) begin
            m = $urandom();
            case ($urandom_range(0, 3))
                0: m = '0;
                1: m = 32'h1 << $urandom_range(0, 31);
                2: m = m & $urandom();
                default: ;
            endcase
            d = $urandom();
            cfg_write(m, d);
            m = $urandom() & $urandom();
            wr(6'h00, m); sel_m = m;
            rd(6'h04, v);
            chk($sformatf("R3 random read sel=%h", m), v, lowest_cfg(m));
        end
        check_pads("R5 random");
        for (int i = 0; i < 32; i++) begin
            wr(6'h00, 32'h1 << i);
            rd(6'h04, v);
            chk($sformatf("R2 line %0d readback", i), v, cfg_m[i]);
        end

        // R4 random set/clear
        for (int it = 0; it < 40; it++) begin
            d = $urandom();
            if ($urandom_range(0, 1) == 0) begin wr(6'h10, d); odat_m |= d; end
            else begin wr(6'h14, d); odat_m &= ~d; end
            rd(6'h18, v);
            chk("R4 output data", v, odat_m);
            chk("R4 out_val", out_val, odat_m);
        end
        wr(6'h10, 32'h0); rd(6'h18, v); chk("R4 zero set ignored", v, odat_m);
        wr(6'h14, 32'h0); rd(6'h18, v); chk("R4 zero clear ignored", v, odat_m);

        // R6 random enable/disable
        for (int it = 0; it < 30; it++) begin
            d = $urandom();
            if ($urandom_range(0, 1) == 0) begin wr(6'h20, d); imsk_m |= d; end
            else begin wr(6'h24, d); imsk_m &= ~d; end
            rd(6'h28, v);
            chk("R6 mask readback", v, imsk_m);
        end
        wr(6'h28, ~imsk_m);
        rd(6'h28, v); chk("R6 mask write ignored", v, imsk_m);

        // R11 zero reads
        rd(6'h0C, v); chk("R11 lock status", v, 32'h0);
        rd(6'h10, v); chk("R11 set offset", v, 32'h0);
        rd(6'h24, v); chk("R11 disable offset", v, 32'h0);
        rd(6'h1C, v); chk("R11 unused 0x1C", v, 32'h0);
        rd(6'h3C, v); chk("R11 unused 0x3C", v, 32'h0);

        // R7 two-edge latency of pin data
        for (int it = 0; it < 8; it++) begin
            logic [31:0] old_p;
            old_p = pins_in;
            d = $urandom();
            @(negedge clk); pins_in = d;
            @(negedge clk); rd_en = 1'b1; addr = 6'h08;
            #1 chk("R7 one edge still old", rdata, old_p);
            @(negedge clk);
            #1 chk("R7 two edges new", rdata, d);
            rd_en = 1'b0;
        end

        // R8/R9/R10 directed events on a fresh bank
        @(negedge clk); pins_in = '0;
        do_reset();
        for (int i = 0; i < 5; i++) cfg_write(32'h1 << i, {5'h0, 3'(i), 24'h0});
        idle(4);
        rd(6'h2C, v);
        chk("R8 low level pending", v, 32'h08);
        idle(4);
        rd(6'h2C, v);
        chk("R9 persisting level reported again", v, 32'h08);
        @(negedge clk); pins_in = 32'h1F;
        idle(4);
        rd(6'h2C, v);
        chk("R8 rise: rise,both,low-before,high", v, 32'h1E);
        idle(4);
        rd(6'h2C, v);
        chk("R9 edges cleared, high level stays", v, 32'h10);
        @(negedge clk); pins_in = 32'h0;
        idle(4);
        rd(6'h2C, v);
        chk("R8 fall: fall,both,low,high-before", v, 32'h1D);
        idle(4);
        rd(6'h2C, v);
        chk("R9 after fall only low level", v, 32'h08);
        chk("R10 pending but masked", {31'h0, irq}, 32'h0);
        wr(6'h20, 32'h08);
        #1 chk("R10 enabled pending raises irq", {31'h0, irq}, 32'h1);
        wr(6'h24, 32'h08);
        #1 chk("R10 disable drops irq", {31'h0, irq}, 32'h0);
        wr(6'h20, 32'h02);
        #1 chk("R10 enabled line not pending", {31'h0, irq}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule